// File: doc/BRIEF.md
# Lockable Dual-View Instruction Memory

This block is the program store of a small coprocessor. The core reads it through a fetch port that returns one 16-bit instruction for each access. The fetch address is a 16-bit program counter that counts instructions, not bytes. A host loads and checks the program through a 32-bit system-bus port that is addressed in bytes. On the bus side, instruction n sits at byte address 2n. The memory depth is a parameter, `WORDS`, given in 32-bit words.

The host loads the program and then sets a sticky lock bit through a control register. From then on the store is read-only from the bus. Every bus write to the array is refused with an error response, and bus reads still work. Any bus access that is not a full aligned word, or that falls past the configured depth, also gets an error response and has no effect. Each bus request gets exactly one response, one cycle later, on `bus_ack`. `bus_err` qualifies that response.

Top module: `code_store`

## Requirements
- R1: A fetch enabled with program counter p gives, one cycle later on `fetch_instr`, one half of 32-bit word p>>1. The half is bits 15:0 when p is even and bits 31:16 when p is odd.
- R2: A fetch with p at or above 2*WORDS gives 16'h0000.
- R3: Every bus request (`bus_req` high for one cycle) gets `bus_ack` high in the next cycle. A legal word write at byte address 4k stores the data in word k, and a later legal read of 4k returns it with `bus_err` low.
- R4: An access with `bus_size` other than 2'b10 (word), or with `bus_addr[1:0]` not zero, is answered with `bus_err` high and read data zero. It does not change the array.
- R5: An array access whose byte address is at or above 4*WORDS is answered with `bus_err` high and read data zero. A write of this kind has no effect.
- R6: An access with `bus_ctl` high targets the lock register. A write with `bus_wdata[0]`=1 sets the lock. A write with bit 0 clear leaves the lock as it is. A read returns the lock in bit 0 and zeros elsewhere. Only reset clears the lock.
- R7: While the lock is set, every array write is answered with `bus_err` high and leaves the array unchanged.
- R8: While the lock is set, array reads still complete with `bus_err` low and correct data, and fetches are unaffected.
- R9: A fetch and a bus write to the same word in the same cycle: the fetch returns the contents from before the write.
- R10: After reset, `bus_ack`, `bus_err`, `bus_rdata` and `fetch_instr` are zero and the lock is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_en | input | 1 | Fetch strobe from the core |
| fetch_pc | input | 16 | Instruction index to fetch |
| fetch_instr | output | 16 | Fetched instruction, one cycle after the strobe |
| bus_req | input | 1 | Bus request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_ctl | input | 1 | 1 = lock register, 0 = array |
| bus_size | input | 2 | Transfer size: 00 byte, 01 half, 10 word, 11 reserved |
| bus_addr | input | BUS_AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with an error-free acknowledge |
| bus_ack | output | 1 | Response strobe, one cycle after the request |
| bus_err | output | 1 | Error flag of the response |

## Verification
The hardest case to reach from the ports is a fetch and a bus write that target the same word in the same clock edge. The read-before-write order only shows in that one cycle. The bench drives both strobes in one task, in the same cycle, and checks that the fetch returns the old half-word. A second fetch then shows the new one. The lock is also hard to test fully, because it can only be cleared by reset. For that reason the locked-state tests run last, and a final reset shows that the lock has cleared and writes work again.

// File: rtl/code_store_pkg.sv
// Shared types for the instruction store.
// Assumes the bus encodes transfer size in two bits.
package code_store_pkg;
    typedef enum logic [1:0] {
        XFER_BYTE = 2'b00,
        XFER_HALF = 2'b01,
        XFER_WORD = 2'b10,
        XFER_RSVD = 2'b11
    } xfer_size_e;
endpackage

// File: rtl/cs_bus_decode.sv
// Combinational decode of one bus access.
// It classifies the access as an array read, array write, lock read or lock
// write, or flags it as an error.
// Assumes a request lasts exactly one cycle.
module cs_bus_decode
    import code_store_pkg::*;
#(
    parameter int BUS_AW = 18,
    parameter int WORDS  = 256,
    parameter int WIDX_W = $clog2(WORDS)
) (
    input  logic              req,
    input  logic              we,
    input  logic              ctl_sel,
    input  logic [BUS_AW-1:0] addr,
    input  logic [1:0]        size,
    input  logic              locked,
    output logic              err,
    output logic              mem_we,
    output logic              mem_re,
    output logic              ctl_we,
    output logic              ctl_re,
    output logic [WIDX_W-1:0] widx
);
    localparam int WA_W = BUS_AW - 2;

    logic [WA_W-1:0] waddr;
    logic shape_ok, in_range, mem_ok, ctl_ok;

    // Classify the access and build the word index.
    always_comb begin
        waddr    = addr[BUS_AW-1:2];
        shape_ok = (xfer_size_e'(size) == XFER_WORD) && (addr[1:0] == 2'b00);
        in_range = ({1'b0, waddr} < (WA_W+1)'(WORDS));
        mem_ok   = shape_ok && !ctl_sel && in_range && !(we && locked);
        ctl_ok   = shape_ok && ctl_sel;
        err      = req && !(mem_ok || ctl_ok);
        mem_we   = req && mem_ok && we;
        mem_re   = req && mem_ok && !we;
        ctl_we   = req && ctl_ok && we;
        ctl_re   = req && ctl_ok && !we;
        widx     = waddr[WIDX_W-1:0];
    end
endmodule

// File: rtl/cs_lock_reg.sv
// Sticky write-barrier bit.
// Software sets it, and only reset clears it.
module cs_lock_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    output logic locked
);
    // Hold the lock once set; reset is the only way out.
    always_ff @(posedge clk) begin
        if (!rst_n)       locked <= 1'b0;
        else if (set_req) locked <= 1'b1;
    end

    // R6
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);
endmodule

// File: rtl/cs_array.sv
// Word array with one bus write port, one registered bus read port and one
// registered half-word fetch port.
// A read in the same cycle as a write to the same word returns the old data.
// Assumes WORDS >= 2 and WORDS <= 32768.
module cs_array #(
    parameter int WORDS  = 256,
    parameter int WIDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [WIDX_W-1:0] widx,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              fetch_en,
    input  logic [15:0]       fetch_pc,
    output logic [15:0]       fetch_instr
);
    localparam logic [16:0] FETCH_LIMIT = 17'(2 * WORDS);

    logic [31:0]       mem [WORDS];
    logic [WIDX_W-1:0] f_widx;
    logic              f_hi, f_in;

    // Split the program counter into word index and half select.
    always_comb begin
        f_widx = fetch_pc[WIDX_W:1];
        f_hi   = fetch_pc[0];
        f_in   = ({1'b0, fetch_pc} < FETCH_LIMIT);
    end

    // Store a bus word.
    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    // Registered bus read.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[widx];
    end

    // Registered instruction fetch; out of range gives zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                fetch_instr <= '0;
        else if (fetch_en && !f_in) fetch_instr <= '0;
        else if (fetch_en)          fetch_instr <= f_hi ? mem[f_widx][31:16] : mem[f_widx][15:0];
    end

    // R2
    fetch_oob_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && !f_in) |=> (fetch_instr == 16'h0000));
endmodule

// File: rtl/code_store.sv
// Top of the lockable dual-view instruction store.
// The core fetches 16-bit instructions by index. The bus sees 32-bit words by
// byte address, and every request gets one response a cycle later.
// Assumes bus requests are single-cycle strobes.
module code_store #(
    parameter int BUS_AW = 18,
    parameter int WORDS  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_en,
    input  logic [15:0]       fetch_pc,
    output logic [15:0]       fetch_instr,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_ctl,
    input  logic [1:0]        bus_size,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ack,
    output logic              bus_err
);
    localparam int WIDX_W = $clog2(WORDS);

    logic              dec_err, mem_we, mem_re, ctl_we, ctl_re, locked;
    logic [WIDX_W-1:0] widx;
    logic [31:0]       arr_rdata;
    logic              ack_q, err_q, ctl_rd_q, ctl_bit_q;

    cs_bus_decode #(.BUS_AW(BUS_AW), .WORDS(WORDS), .WIDX_W(WIDX_W)) i_dec (
        .req(bus_req), .we(bus_we), .ctl_sel(bus_ctl), .addr(bus_addr),
        .size(bus_size), .locked(locked), .err(dec_err), .mem_we(mem_we),
        .mem_re(mem_re), .ctl_we(ctl_we), .ctl_re(ctl_re), .widx(widx)
    );

    cs_lock_reg i_lock (
        .clk(clk), .rst_n(rst_n), .set_req(ctl_we && bus_wdata[0]), .locked(locked)
    );

    cs_array #(.WORDS(WORDS), .WIDX_W(WIDX_W)) i_arr (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .re(mem_re), .widx(widx),
        .wdata(bus_wdata), .rdata(arr_rdata), .fetch_en(fetch_en),
        .fetch_pc(fetch_pc), .fetch_instr(fetch_instr)
    );

    // Response state: strobe, error flag, lock readback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q     <= 1'b0;
            err_q     <= 1'b0;
            ctl_rd_q  <= 1'b0;
            ctl_bit_q <= 1'b0;
        end else begin
            ack_q    <= bus_req;
            err_q    <= dec_err;
            ctl_rd_q <= ctl_re;
            if (ctl_re) ctl_bit_q <= locked;
        end
    end

    // Select the returned data; errors return zero.
    always_comb begin
        bus_ack = ack_q;
        bus_err = err_q;
        if (!ack_q || err_q) bus_rdata = '0;
        else if (ctl_rd_q)   bus_rdata = {31'b0, ctl_bit_q};
        else                 bus_rdata = arr_rdata;
    end

    // R3
    one_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> bus_ack);
    // R4
    bad_shape_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && (bus_size != 2'b10 || bus_addr[1:0] != 2'b00)) |=> bus_err);
    // R5
    oob_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ctl && ({1'b0, bus_addr[BUS_AW-1:2]} >= (BUS_AW-1)'(WORDS))) |=> bus_err);
    // R7
    locked_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && !bus_ctl && locked) |=> bus_err);
endmodule

// File: tb/test_code_store.sv
// Directed bench for code_store: one task per scenario.
module test_code_store;
    localparam int BUS_AW = 18;
    localparam int WORDS  = 256;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fetch_en = 1'b0;
    logic [15:0]       fetch_pc = '0;
    logic [15:0]       fetch_instr;
    logic              bus_req = 1'b0, bus_we = 1'b0, bus_ctl = 1'b0;
    logic [1:0]        bus_size = 2'b10;
    logic [BUS_AW-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_ack, bus_err;

    int n_checks = 0;
    int n_fails  = 0;

    code_store #(.BUS_AW(BUS_AW), .WORDS(WORDS)) i_code_store (.*);

    always #10 clk = ~clk;  // 50 MHz

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One bus access; samples the response one cycle later.
    task automatic bus(input logic ctl, input logic we, input logic [BUS_AW-1:0] a,
                       input logic [1:0] sz, input logic [31:0] wd,
                       output logic err, output logic [31:0] rd);
        @(negedge clk);
        bus_req = 1'b1; bus_ctl = ctl; bus_we = we; bus_addr = a;
        bus_size = sz; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
        check("R3 ack", {31'b0, bus_ack}, 32'd1);
        err = bus_err;
        rd  = bus_rdata;
    endtask

    task automatic fetch(input logic [15:0] pc, output logic [15:0] ins);
        @(negedge clk);
        fetch_en = 1'b1; fetch_pc = pc;
        @(negedge clk);
        fetch_en = 1'b0;
        ins = fetch_instr;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check("R10 ack", {31'b0, bus_ack}, 0);
        check("R10 err", {31'b0, bus_err}, 0);
        check("R10 rdata", bus_rdata, 0);
        check("R10 instr", {16'b0, fetch_instr}, 0);
    endtask

    task automatic t_load();
        logic e; logic [31:0] d;
        bus(0, 1, 18'h0, 2'b10, 32'hBBBB_AAAA, e, d); check("R3 wr err", {31'b0, e}, 0);
        bus(0, 1, 18'h4, 2'b10, 32'h2222_1111, e, d); check("R3 wr err", {31'b0, e}, 0);
        bus(0, 1, 18'h3FC, 2'b10, 32'hCAFE_F00D, e, d); check("R3 wr err", {31'b0, e}, 0);
        bus(0, 0, 18'h4, 2'b10, 0, e, d);
        check("R3 rd err", {31'b0, e}, 0); check("R3 rd data", d, 32'h2222_1111);
        bus(0, 0, 18'h3FC, 2'b10, 0, e, d); check("R3 rd last", d, 32'hCAFE_F00D);
    endtask

    task automatic t_fetch();
        logic [15:0] i;
        fetch(16'd0, i);   check("R1 pc0", {16'b0, i}, 32'hAAAA);
        fetch(16'd1, i);   check("R1 pc1", {16'b0, i}, 32'hBBBB);
        fetch(16'd3, i);   check("R1 pc3", {16'b0, i}, 32'h2222);
        fetch(16'd511, i); check("R1 pc511", {16'b0, i}, 32'hCAFE);
        fetch(16'd512, i); check("R2 pc512", {16'b0, i}, 0);
        fetch(16'd2, i);   check("R1 pc2", {16'b0, i}, 32'h1111);
        fetch(16'hFFFF, i); check("R2 pcFFFF", {16'b0, i}, 0);
    endtask

    task automatic t_bad();
        logic e; logic [31:0] d;
        bus(0, 1, 18'h2, 2'b10, 32'hDEAD_DEAD, e, d); check("R4 misalign err", {31'b0, e}, 1);
        bus(0, 1, 18'h0, 2'b01, 32'hDEAD_DEAD, e, d); check("R4 half err", {31'b0, e}, 1);
        bus(0, 0, 18'h0, 2'b00, 0, e, d); check("R4 byte rd err", {31'b0, e}, 1);
        check("R4 byte rd data", d, 0);
        bus(0, 0, 18'h0, 2'b10, 0, e, d); check("R4 unchanged", d, 32'hBBBB_AAAA);
        bus(0, 1, 18'h400, 2'b10, 32'h5555_5555, e, d); check("R5 oob wr err", {31'b0, e}, 1);
        bus(0, 0, 18'h400, 2'b10, 0, e, d); check("R5 oob rd err", {31'b0, e}, 1);
        check("R5 oob rd data", d, 0);
        bus(0, 0, 18'h0, 2'b10, 0, e, d); check("R5 no alias", d, 32'hBBBB_AAAA);
    endtask

    task automatic t_collide();
        logic [15:0] i;
        @(negedge clk);
        fetch_en = 1'b1; fetch_pc = 16'd1;
        bus_req = 1'b1; bus_ctl = 0; bus_we = 1; bus_addr = 18'h0;
        bus_size = 2'b10; bus_wdata = 32'h7777_6666;
        @(negedge clk);
        fetch_en = 1'b0; bus_req = 1'b0;
        check("R9 old data", {16'b0, fetch_instr}, 32'hBBBB);
        fetch(16'd1, i); check("R9 new data", {16'b0, i}, 32'h7777);
    endtask

    task automatic t_lock();
        logic e; logic [31:0] d; logic [15:0] i;
        bus(1, 0, 18'h0, 2'b10, 0, e, d); check("R6 initial", d, 0);
        bus(1, 1, 18'h0, 2'b10, 1, e, d); check("R6 set err", {31'b0, e}, 0);
        bus(1, 0, 18'h0, 2'b10, 0, e, d); check("R6 readback", d, 1);
        bus(1, 1, 18'h0, 2'b10, 0, e, d);
        bus(1, 0, 18'h0, 2'b10, 0, e, d); check("R6 sticky", d, 1);
        bus(0, 1, 18'h4, 2'b10, 32'h9999_9999, e, d); check("R7 locked wr err", {31'b0, e}, 1);
        bus(0, 0, 18'h4, 2'b10, 0, e, d);
        check("R8 rd err", {31'b0, e}, 0); check("R7 unchanged", d, 32'h2222_1111);
        fetch(16'd2, i); check("R8 fetch", {16'b0, i}, 32'h1111);
        do_reset();
        bus(1, 0, 18'h0, 2'b10, 0, e, d); check("R6 reset clears", d, 0);
        bus(0, 1, 18'h4, 2'b10, 32'h4444_3333, e, d); check("R6 wr after reset", {31'b0, e}, 0);
        bus(0, 0, 18'h4, 2'b10, 0, e, d); check("R3 wr after reset", d, 32'h4444_3333);
    endtask

    initial begin
        t_reset();
        t_load();
        t_fetch();
        t_bad();
        t_collide();
        t_lock();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule